// File: doc/BRIEF.md
# Transmit character framer

The framer turns a stream of 16-bit words into the byte-wide character stream that feeds an 8b/10b serial link encoder. Each character carries a K flag. The character stream runs on its own line clock, at twice the word rate. Words arrive on a separate word clock and cross into the line domain through a small internal dual-clock buffer whose pointers are Gray coded.

Every unit on the line is a pair of characters. The first character of a pair names its kind, except for a data pair, whose two bytes are both plain data. Between data pairs the framer inserts:
- idle pairs, which carry a link-ready indication for the far end;
- one-byte control messages;
- retransmit-start markers;
- link-reset characters, which are repeated for as long as a reset is requested.

A transmit-allow gate holds back everything except idles and reset characters until the local link is usable.

Control messages and retransmit-start markers are requested by a one-cycle strobe in the line domain. The framer remembers a request until a pair boundary lets it go out. When several kinds of traffic are waiting, the highest-priority one goes first.

Top module: `lineFramerTx`

## Requirements
- R1: While `lineRst` is high, the output is 0xBC with K=1, and all pending requests are cleared, so the first pair after reset is an idle pair.
- R2: Characters alternate between the first and second position of a pair, and a new pair starts only on a pair boundary. Every first character has K=1 except in a data pair. Every second character has K=0 except in a link-reset pair.
- R3: An idle pair is 0xBC (K=1) followed by a data character with K=0. That character is 0xC5 (ready) when `txAllow` was high at the start of the pair, and 0x50 (not ready) otherwise.
- R4: A buffered word is sent as its bits 7:0, then its bits 15:8, both with K=0. Words go out in write order, each exactly once.
- R5: A `msgStrobe` latches `msgWord` and makes a message pending. The message pair is 0xDC (K=1) followed by the latched word. A strobe in the same cycle that a message pair starts is kept, and sent in a later pair.
- R6: A `retrStrobe` latches `retrPos` and makes a retransmit-start pending. The marker pair is 0x7C (K=1) followed by the latched position.
- R7: When `linkResetReq` is high at a pair boundary, the pair is 0xFE (K=1) twice. This happens whatever the value of `txAllow`, and a held request produces back-to-back reset pairs with no idle between them.
- R8: At a pair boundary the framer picks, from highest to lowest priority: link reset, retransmit-start, control message, data word, idle.
- R9: While `txAllow` is low, only idle pairs or link-reset pairs start. Pending messages, retransmit markers and buffered words are kept, and go out once `txAllow` is high.
- R10: A buffered word starts transmission no later than the first pair boundary that comes at least 6 line-clock edges after the word-clock edge that wrote it. This holds when `txAllow` is high and nothing of higher priority is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wordClk | input | 1 | Word-side clock |
| wordRst | input | 1 | Synchronous reset, word domain, active high |
| wordData | input | 16 | Word to transmit |
| wordWrite | input | 1 | Writes `wordData` into the crossing buffer |
| lineClk | input | 1 | Character clock, twice the word rate |
| lineRst | input | 1 | Synchronous reset, line domain, active high |
| txAllow | input | 1 | Permits data, messages and retransmit markers |
| linkResetReq | input | 1 | Requests link-reset characters while high |
| msgStrobe | input | 1 | One-cycle request to send a control message |
| msgWord | input | 8 | Control message byte |
| retrStrobe | input | 1 | One-cycle request to send a retransmit-start marker |
| retrPos | input | 8 | Retransmit position |
| lineChar | output | 8 | Character to the encoder |
| lineIsK | output | 1 | K flag of `lineChar` |

## Verification
If the pair-phase bit is wrong, the very next character shows it: a K code appears in a second position, or a plain byte appears where a pair must start. A pending flag that is lost or stuck shows up at the next pair boundary where that request should win, as a missing or repeated 0xDC or 0x7C pair, or as one carrying a stale byte. A fault in the buffer pointers or in their synchronisers shows at the line as bytes swapped, repeated or dropped, or as idles that continue past the 6-edge bound. The bench follows the character stream on every line-clock edge, so any of these faults is caught within one pair of the event.

// File: rtl/lineFramerPkg.sv
package lineFramerPkg;

  localparam logic [7:0] CH_COMMA    = 8'hBC;  // idle pair opener
  localparam logic [7:0] CH_MSG      = 8'hDC;  // control message opener
  localparam logic [7:0] CH_RETR     = 8'h7C;  // retransmit-start opener
  localparam logic [7:0] CH_LRST     = 8'hFE;  // link reset character
  localparam logic [7:0] CH_NOTREADY = 8'h50;  // idle filler, link not ready
  localparam logic [7:0] CH_READY    = 8'hC5;  // idle filler, link ready

  typedef enum logic [2:0] {
    PK_IDLE,
    PK_DATA,
    PK_MSG,
    PK_RETR,
    PK_LRST
  } pairKind_t;

  typedef struct packed {
    logic      firstHalf;  // this edge emits the first character of a pair
    pairKind_t kind;       // kind chosen for the pair starting now
    logic      readyIdle;  // idle filler selects the ready variant
    logic      latchMsg;   // capture the message byte
    logic      latchRetr;  // capture the retransmit position
  } ctlStrobes_t;

endpackage

// File: rtl/graySync.sv
module graySync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= din;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/wordCrossBuffer.sv
module wordCrossBuffer #(
  parameter int AW          = 3,   // log2 of depth, at least 2
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wClk,
  input  logic          wRst,
  input  logic          wEn,
  input  logic [DW-1:0] wData,
  input  logic          rClk,
  input  logic          rRst,
  input  logic          rPop,
  output logic [DW-1:0] rData,
  output logic          rEmpty
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wrBin, wrGray, wrNext, rdGraySync;
  logic          full, doWrite;

  assign wrNext  = wrBin + {{AW{1'b0}}, 1'b1};
  assign full    = (wrGray == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
  assign doWrite = wEn && !full;

  always_ff @(posedge wClk) begin
    if (wRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (doWrite) begin
      wrBin  <= wrNext;
      wrGray <= toGray(wrNext);
    end
  end

  always_ff @(posedge wClk) begin
    if (doWrite) mem[wrBin[AW-1:0]] <= wData;
  end

  // read domain
  logic [PW-1:0] rdBin, rdGray, rdNext, wrGraySync;
  logic          doRead;

  assign rdNext = rdBin + {{AW{1'b0}}, 1'b1};
  assign rEmpty = (rdGray == wrGraySync);
  assign doRead = rPop && !rEmpty;
  assign rData  = mem[rdBin[AW-1:0]];

  always_ff @(posedge rClk) begin
    if (rRst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (doRead) begin
      rdBin  <= rdNext;
      rdGray <= toGray(rdNext);
    end
  end

  graySync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk (rClk),
    .rst (rRst),
    .din (wrGray),
    .dout(wrGraySync)
  );

  graySync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk (wClk),
    .rst (wRst),
    .din (rdGray),
    .dout(rdGraySync)
  );

endmodule

// File: rtl/framerCtrl.sv
module framerCtrl
  import lineFramerPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        txAllow,
  input  logic        linkResetReq,
  input  logic        msgStrobe,
  input  logic        retrStrobe,
  input  logic        wordAvail,
  output ctlStrobes_t strb,
  output logic        popWord
);

  logic      hiPhase;   // next edge emits the second character
  logic      msgPend;
  logic      retrPend;
  pairKind_t pick;

  // R8: fixed priority at each pair boundary; R9: gate blocks all but idle/reset
  always_comb begin
    if (linkResetReq)             pick = PK_LRST;
    else if (txAllow && retrPend) pick = PK_RETR;
    else if (txAllow && msgPend)  pick = PK_MSG;
    else if (txAllow && wordAvail) pick = PK_DATA;
    else                          pick = PK_IDLE;
  end

  always_comb begin
    strb.firstHalf = !hiPhase;
    strb.kind      = pick;
    strb.readyIdle = txAllow;
    strb.latchMsg  = msgStrobe;
    strb.latchRetr = retrStrobe;
  end

  assign popWord = !hiPhase && (pick == PK_DATA);

  // R5/R6: requests stay pending until their pair starts; a new strobe re-arms
  always_ff @(posedge clk) begin
    if (rst) begin
      hiPhase  <= 1'b0;
      msgPend  <= 1'b0;
      retrPend <= 1'b0;
    end else begin
      hiPhase  <= !hiPhase;
      msgPend  <= msgStrobe  || (msgPend  && !(!hiPhase && pick == PK_MSG));
      retrPend <= retrStrobe || (retrPend && !(!hiPhase && pick == PK_RETR));
    end
  end

endmodule

// File: rtl/framerDatapath.sv
module framerDatapath
  import lineFramerPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctlStrobes_t strb,
  input  logic [15:0] headWord,
  input  logic [7:0]  msgWord,
  input  logic [7:0]  retrPos,
  output logic [7:0]  lineChar,
  output logic        lineIsK
);

  logic [7:0] msgReg, retrReg, nextChar;
  logic       nextIsK;

  always_ff @(posedge clk) begin
    if (rst) begin
      msgReg  <= '0;
      retrReg <= '0;
    end else begin
      if (strb.latchMsg)  msgReg  <= msgWord;
      if (strb.latchRetr) retrReg <= retrPos;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineChar <= CH_COMMA;  // R1
      lineIsK  <= 1'b1;
      nextChar <= CH_NOTREADY;
      nextIsK  <= 1'b0;
    end else if (strb.firstHalf) begin
      unique case (strb.kind)
        PK_DATA: begin  // R4: low byte first
          lineChar <= headWord[7:0];
          lineIsK  <= 1'b0;
          nextChar <= headWord[15:8];
          nextIsK  <= 1'b0;
        end
        PK_MSG: begin   // R5
          lineChar <= CH_MSG;
          lineIsK  <= 1'b1;
          nextChar <= msgReg;
          nextIsK  <= 1'b0;
        end
        PK_RETR: begin  // R6
          lineChar <= CH_RETR;
          lineIsK  <= 1'b1;
          nextChar <= retrReg;
          nextIsK  <= 1'b0;
        end
        PK_LRST: begin  // R7
          lineChar <= CH_LRST;
          lineIsK  <= 1'b1;
          nextChar <= CH_LRST;
          nextIsK  <= 1'b1;
        end
        default: begin  // R3
          lineChar <= CH_COMMA;
          lineIsK  <= 1'b1;
          nextChar <= strb.readyIdle ? CH_READY : CH_NOTREADY;
          nextIsK  <= 1'b0;
        end
      endcase
    end else begin
      lineChar <= nextChar;  // R2
      lineIsK  <= nextIsK;
    end
  end

endmodule

// File: rtl/lineFramerTx.sv
module lineFramerTx
  import lineFramerPkg::*;
#(
  parameter int BUF_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic        wordClk,
  input  logic        wordRst,
  input  logic [15:0] wordData,
  input  logic        wordWrite,
  input  logic        lineClk,
  input  logic        lineRst,
  input  logic        txAllow,
  input  logic        linkResetReq,
  input  logic        msgStrobe,
  input  logic [7:0]  msgWord,
  input  logic        retrStrobe,
  input  logic [7:0]  retrPos,
  output logic [7:0]  lineChar,
  output logic        lineIsK
);

  localparam int WORD_W = 16;

  ctlStrobes_t       strb;
  logic              popWord;
  logic              bufEmpty;
  logic [WORD_W-1:0] headWord;

  wordCrossBuffer #(.AW(BUF_AW), .DW(WORD_W), .SYNC_STAGES(SYNC_STAGES)) uBuf (
    .wClk  (wordClk),
    .wRst  (wordRst),
    .wEn   (wordWrite),
    .wData (wordData),
    .rClk  (lineClk),
    .rRst  (lineRst),
    .rPop  (popWord),
    .rData (headWord),
    .rEmpty(bufEmpty)
  );

  framerCtrl uCtrl (
    .clk         (lineClk),
    .rst         (lineRst),
    .txAllow     (txAllow),
    .linkResetReq(linkResetReq),
    .msgStrobe   (msgStrobe),
    .retrStrobe  (retrStrobe),
    .wordAvail   (!bufEmpty),
    .strb        (strb),
    .popWord     (popWord)
  );

  framerDatapath uPath (
    .clk     (lineClk),
    .rst     (lineRst),
    .strb    (strb),
    .headWord(headWord),
    .msgWord (msgWord),
    .retrPos (retrPos),
    .lineChar(lineChar),
    .lineIsK (lineIsK)
  );

endmodule

// File: rtl/lineFramerTxChecker.sv
module lineFramerTxChecker (
  input logic       lineClk,
  input logic       lineRst,
  input logic       txAllow,
  input logic       linkResetReq,
  input logic [7:0] lineChar,
  input logic       lineIsK
);

  logic ckNextFirst;  // next edge emits a first character
  logic ckFirst;      // current output is a first character

  always_ff @(posedge lineClk) begin
    if (lineRst) begin
      ckNextFirst <= 1'b1;
      ckFirst     <= 1'b0;
    end else begin
      ckNextFirst <= !ckNextFirst;
      ckFirst     <= ckNextFirst;
    end
  end

  // R1
  a_r1_reset_value: assert property (@(posedge lineClk)
    lineRst |=> (lineIsK && lineChar == 8'hBC));

  // R2
  a_r2_legal_opener: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckFirst && lineIsK) |-> (lineChar == 8'hBC || lineChar == 8'hDC ||
                              lineChar == 8'h7C || lineChar == 8'hFE));

  a_r2_second_plain: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckFirst && !(lineIsK && lineChar == 8'hFE)) |=> !lineIsK);

  // R3
  a_r3_idle_filler: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckFirst && lineIsK && lineChar == 8'hBC) |=> (lineChar == 8'hC5 || lineChar == 8'h50));

  // R7
  a_r7_reset_pair: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckFirst && lineIsK && lineChar == 8'hFE) |=> (lineIsK && lineChar == 8'hFE));

  a_r7_reset_wins: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckNextFirst && linkResetReq) |=> (lineIsK && lineChar == 8'hFE));

  // R9
  a_r9_gate_closed: assert property (@(posedge lineClk) disable iff (lineRst)
    (ckNextFirst && !txAllow) |=> (lineIsK && (lineChar == 8'hBC || lineChar == 8'hFE)));

endmodule

bind lineFramerTx lineFramerTxChecker uChk (.*);

// File: tb/tb_lineFramerTx.sv
`timescale 1ns/1ps
module tb_lineFramerTx;

  logic        wordClk = 1'b0, lineClk = 1'b0;
  logic        wordRst = 1'b1, lineRst = 1'b1;
  logic [15:0] wordData = '0;
  logic        wordWrite = 1'b0;
  logic        txAllow = 1'b0, linkResetReq = 1'b0;
  logic        msgStrobe = 1'b0, retrStrobe = 1'b0;
  logic [7:0]  msgWord = '0, retrPos = '0;
  logic [7:0]  lineChar;
  logic        lineIsK;

  lineFramerTx dut (.*);

  always #4 lineClk = ~lineClk;            // 125 MHz
  initial begin #3; forever #8 wordClk = ~wordClk; end

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  localparam int LAT = 6;

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs seen at each line edge
  logic       sRst = 1'b1, sAllow = 1'b0, sRstReq = 1'b0, sMsg = 1'b0, sRetr = 1'b0;
  logic [7:0] sMsgW = '0, sRetrP = '0;
  int         fastCount = 0;
  always @(posedge lineClk) begin
    sRst <= lineRst; sAllow <= txAllow; sRstReq <= linkResetReq;
    sMsg <= msgStrobe; sMsgW <= msgWord; sRetr <= retrStrobe; sRetrP <= retrPos;
    fastCount <= fastCount + 1;
  end

  logic [15:0] q[$];
  int          qT[$];
  always @(posedge wordClk) begin
    if (!wordRst && wordWrite) begin
      q.push_back(wordData);
      qT.push_back(fastCount);
    end
  end

  // behavioural reference
  bit         mFirstNext = 1'b1, mMsgPend = 1'b0, mRetrPend = 1'b0;
  logic [7:0] mMsgW = '0, mRetrP = '0;
  logic [8:0] mSecond = '0;
  always @(negedge lineClk) begin
    logic [8:0] act, exp;
    string tag;
    act = {lineIsK, lineChar};
    if (sRst) begin
      check(act == 9'h1BC, "R1", act, 9'h1BC);
      mFirstNext = 1'b1; mMsgPend = 1'b0; mRetrPend = 1'b0;
    end else if (mFirstNext) begin
      if (sRstReq) begin
        exp = 9'h1FE; mSecond = 9'h1FE;
        tag = (mMsgPend || mRetrPend || q.size() > 0) ? "R8" : "R7";
      end else if (sAllow && mRetrPend) begin
        exp = 9'h17C; mSecond = {1'b0, mRetrP}; mRetrPend = 1'b0;
        tag = (mMsgPend || q.size() > 0) ? "R8" : "R6";
      end else if (sAllow && mMsgPend) begin
        exp = 9'h1DC; mSecond = {1'b0, mMsgW}; mMsgPend = 1'b0;
        tag = (q.size() > 0) ? "R8" : "R5";
      end else if (sAllow && q.size() > 0) begin
        if (act == {1'b0, q[0][7:0]}) begin
          exp = act; mSecond = {1'b0, q[0][15:8]}; tag = "R4";
          void'(q.pop_front()); void'(qT.pop_front());
        end else if (fastCount - qT[0] < LAT) begin
          exp = 9'h1BC; mSecond = 9'h0C5; tag = "R10";
        end else begin
          exp = {1'b0, q[0][7:0]}; mSecond = {1'b0, q[0][15:8]}; tag = "R10";
          void'(q.pop_front()); void'(qT.pop_front());
        end
      end else begin
        exp = 9'h1BC; mSecond = sAllow ? 9'h0C5 : 9'h050;
        tag = sAllow ? "R3" : "R9";
      end
      check(act == exp, tag, act, exp);
      if (sMsg)  begin mMsgPend  = 1'b1; mMsgW  = sMsgW;  end
      if (sRetr) begin mRetrPend = 1'b1; mRetrP = sRetrP; end
      mFirstNext = 1'b0;
    end else begin
      check(act == mSecond, "R2", act, mSecond);
      if (sMsg)  begin mMsgPend  = 1'b1; mMsgW  = sMsgW;  end
      if (sRetr) begin mRetrPend = 1'b1; mRetrP = sRetrP; end
      mFirstNext = 1'b1;
    end
  end

  task automatic lineCycles(input int n);
    repeat (n) @(negedge lineClk);
  endtask

  task automatic writeWord(input logic [15:0] w);
    @(negedge wordClk);
    wordData = w; wordWrite = 1'b1;
    @(negedge wordClk);
    wordWrite = 1'b0;
  endtask

  task automatic pulseMsg(input logic [7:0] w);
    @(negedge lineClk); msgStrobe = 1'b1; msgWord = w;
    @(negedge lineClk); msgStrobe = 1'b0;
  endtask

  task automatic pulseRetr(input logic [7:0] p);
    @(negedge lineClk); retrStrobe = 1'b1; retrPos = p;
    @(negedge lineClk); retrStrobe = 1'b0;
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge lineClk);
    checks++; fails++;
    $display("FAIL watchdog expired, run did not complete");
    finishRun();
  end

  initial begin
    // R1: reset state
    lineCycles(6);
    lineRst = 1'b0; wordRst = 1'b0;
    // R9/R3: gate closed gives not-ready idles
    lineCycles(12);
    txAllow = 1'b1;
    lineCycles(12);
    // R4/R10: words in order
    writeWord(16'h1234); writeWord(16'hABCD); writeWord(16'h0F0E); writeWord(16'h8001);
    lineCycles(40);
    // R5: single and back-to-back messages
    pulseMsg(8'hA5);
    lineCycles(8);
    @(negedge lineClk); msgStrobe = 1'b1; msgWord = 8'h11;
    @(negedge lineClk); msgWord = 8'h22;
    @(negedge lineClk); msgStrobe = 1'b0;
    lineCycles(12);
    // R6
    pulseRetr(8'h3C);
    lineCycles(8);
    // R9/R8: everything held while gated, then released by priority
    txAllow = 1'b0;
    writeWord(16'h5566); writeWord(16'h7788); writeWord(16'h99AA);
    pulseMsg(8'h5A);
    pulseRetr(8'h77);
    lineCycles(20);
    txAllow = 1'b1;
    lineCycles(30);
    // R7/R8: reset beats a pending message
    pulseMsg(8'h66);
    linkResetReq = 1'b1;
    lineCycles(9);
    linkResetReq = 1'b0;
    lineCycles(16);
    // R7: reset with the gate closed
    txAllow = 1'b0;
    @(negedge lineClk); linkResetReq = 1'b1;
    lineCycles(6);
    linkResetReq = 1'b0;
    lineCycles(6);
    txAllow = 1'b1;
    // R4/R8: data and message requested together
    fork
      begin writeWord(16'hC3D4); writeWord(16'hE5F6); end
      pulseMsg(8'h99);
    join
    lineCycles(30);
    finishRun();
  end

endmodule